// File: doc/BRIEF.md
# DDR SDRAM Access Command Sequencer

This block sits between a simple single-request user port and the command/address pins of a DDR SDRAM. Each accepted request carries a direction, a bank, a row, a starting column, a burst-length code and an auto-precharge flag. The block turns it into the command series the memory needs: a row-open (ACTIVE) with bank and row, a wait of tRCD clocks, then a READ or WRITE with bank and starting column. If the bank already holds a different open row, that row is first closed with a PRECHARGE and tRP is observed before the new ACTIVE.

A small table holds the open row of each bank. A request that hits the open row goes straight to the column command. A column command with the auto-precharge flag set makes the memory close the row by itself at the end of the burst, so the table marks that bank closed and no explicit PRECHARGE follows. After every column command the block stays busy for the burst, plus the write recovery time after a write and the precharge time after auto-precharge. It then becomes ready again. Every clock edge that issues no command drives a NOP. Initialization and refresh are assumed to be handled elsewhere.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1 and the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 4'b0111, with cmd_ba and cmd_addr zero.
- R2: A request to a bank with no open row is accepted on a clock edge where req_valid and req_ready are both 1. That same edge drives ACTIVE = 4'b0011 with cmd_ba = bank and cmd_addr = row.
- R3: The READ (4'b0101) or WRITE (4'b0100) follows its ACTIVE exactly T_RCD clocks later. Its cmd_addr carries the column on bits 8:0, the auto-precharge flag on bit 10, and zeros on bits 12:11 and 9.
- R4: A request whose bank holds an open row equal to the requested row issues the READ/WRITE on the acceptance edge, with no ACTIVE.
- R5: A request whose bank holds a different open row first issues PRECHARGE = 4'b0010 on the acceptance edge, with cmd_ba = bank and cmd_addr = 0 (bit 10 low, single bank). ACTIVE follows exactly T_RP clocks later.
- R6: A column command with the auto-precharge flag set leaves that bank closed, so the next request to that bank starts with ACTIVE even for the same row.
- R7: The burst code gives the burst length: 0 gives 2, 1 gives 4, and 2 or 3 give 8. The burst occupies length/2 clocks.
- R8: req_ready is 0 from the acceptance edge until HOLD edges after the column command edge, where HOLD = length/2, plus T_WR for a write, plus T_RP when auto-precharge is set.
- R9: While req_valid is 0 no command is issued whatever the other request inputs are. Every edge that issues no command drives NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the access |
| req_row | input | 13 | Row of the access |
| req_col | input | 9 | Starting column of the burst |
| req_autopre | input | 1 | Close the row by itself after the burst |
| req_burst | input | 2 | Burst-length code (0:2, 1:4, 2/3:8) |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address of the command |
| cmd_addr | output | 13 | Address bus of the command |

## Verification
The assertions assume the user side changes the request fields and req_valid only between clock edges. They also assume that an offered request either is accepted or is withdrawn, and that the memory timing parameters are at least one clock. The timing gaps are checked against the last ACTIVE and the last PRECHARGE seen on the pins. This is sound only because the block serves one request at a time. The stimulus waits for req_ready before offering each request and drops req_valid on the cycle after acceptance. It holds arbitrary field values with req_valid low only between requests.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    localparam int BANK_W  = 2;
    localparam int ROW_W   = 13;
    localparam int COL_W   = 9;
    localparam int ADDR_W  = 13;
    localparam int NBANK   = 1 << BANK_W;
    localparam int AP_BIT  = 10;

    // Pin order: cs_n, ras_n, cas_n, we_n
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_RP,
        ST_WAIT_RCD,
        ST_BURST
    } state_e;

    typedef struct packed {
        logic              write;
        logic              autopre;
        logic [1:0]        burst;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } req_t;

    typedef struct packed {
        cmd_e              kind;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
    } bus_t;

    // Clocks occupied by a burst (two words per clock)
    function automatic int burst_clocks(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

    // Column-phase address: column low, auto-precharge on bit 10
    function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] col,
                                                    input logic ap);
        logic [ADDR_W-1:0] a;
        a = '0;
        a[COL_W-1:0] = col;
        a[AP_BIT]    = ap;
        return a;
    endfunction

endpackage

// File: rtl/ddr_seq_timer.sv
module ddr_seq_timer #(
    parameter int TMR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/ddr_seq_bank_table.sv
module ddr_seq_bank_table
    import ddr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_open,
    output logic [ROW_W-1:0]  rd_row,
    input  logic              set_open,
    input  logic              clr_open,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row
);
    logic [NBANK-1:0]            open_q;
    logic [NBANK-1:0][ROW_W-1:0] row_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (set_open && wr_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= wr_row;
            end else if (clr_open && wr_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b0;
            end
        end
    end

    assign rd_open = open_q[rd_bank];
    assign rd_row  = row_q[rd_bank];
endmodule

// File: rtl/ddr_seq_cmd_reg.sv
module ddr_seq_cmd_reg
    import ddr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_t              nxt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);
    bus_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.kind <= CMD_NOP;
            q.ba   <= '0;
            q.addr <= '0;
        end else begin
            q <= nxt;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = q.kind;
    assign ba   = q.ba;
    assign addr = q.addr;
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_WR  = 2,
    parameter int TMR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_autopre,
    input  logic [1:0]        req_burst,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [BANK_W-1:0] cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam logic [TMR_W-1:0] RCD_M1 = TMR_W'(T_RCD - 1);
    localparam logic [TMR_W-1:0] RP_M1  = TMR_W'(T_RP - 1);

    state_e           state, state_n;
    req_t             req_in, req_q, src;
    bus_t             emit;
    logic             capture;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             tbl_set, tbl_clr;
    logic             bank_open;
    logic [ROW_W-1:0] bank_row;

    // Busy time after a column command, minus one
    function automatic logic [TMR_W-1:0] hold_m1(input req_t r);
        int h;
        h = burst_clocks(r.burst) + (r.write ? T_WR : 0) + (r.autopre ? T_RP : 0);
        return TMR_W'(h - 1);
    endfunction

    assign req_in = '{write:   req_write,
                      autopre: req_autopre,
                      burst:   req_burst,
                      bank:    req_bank,
                      row:     req_row,
                      col:     req_col};

    assign src       = (state == ST_IDLE) ? req_in : req_q;
    assign req_ready = (state == ST_IDLE);

    always_comb begin
        state_n   = state;
        emit.kind = CMD_NOP;
        emit.ba   = '0;
        emit.addr = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tbl_set   = 1'b0;
        tbl_clr   = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    capture = 1'b1;
                    if (bank_open && bank_row == src.row) begin
                        emit.kind = src.write ? CMD_WR : CMD_RD;
                        emit.ba   = src.bank;
                        emit.addr = col_addr(src.col, src.autopre);
                        tmr_load  = 1'b1;
                        tmr_val   = hold_m1(src);
                        tbl_clr   = src.autopre;
                        state_n   = ST_BURST;
                    end else if (bank_open) begin
                        emit.kind = CMD_PRE;
                        emit.ba   = src.bank;
                        tmr_load  = 1'b1;
                        tmr_val   = RP_M1;
                        tbl_clr   = 1'b1;
                        state_n   = ST_WAIT_RP;
                    end else begin
                        emit.kind = CMD_ACT;
                        emit.ba   = src.bank;
                        emit.addr = ADDR_W'(src.row);
                        tmr_load  = 1'b1;
                        tmr_val   = RCD_M1;
                        tbl_set   = 1'b1;
                        state_n   = ST_WAIT_RCD;
                    end
                end
            end
            ST_WAIT_RP: begin
                if (tmr_zero) begin
                    emit.kind = CMD_ACT;
                    emit.ba   = src.bank;
                    emit.addr = ADDR_W'(src.row);
                    tmr_load  = 1'b1;
                    tmr_val   = RCD_M1;
                    tbl_set   = 1'b1;
                    state_n   = ST_WAIT_RCD;
                end
            end
            ST_WAIT_RCD: begin
                if (tmr_zero) begin
                    emit.kind = src.write ? CMD_WR : CMD_RD;
                    emit.ba   = src.bank;
                    emit.addr = col_addr(src.col, src.autopre);
                    tmr_load  = 1'b1;
                    tmr_val   = hold_m1(src);
                    tbl_clr   = src.autopre;
                    state_n   = ST_BURST;
                end
            end
            ST_BURST: begin
                if (tmr_zero) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            state <= state_n;
            if (capture) begin
                req_q <= req_in;
            end
        end
    end

    ddr_seq_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ddr_seq_bank_table u_banks (
        .clk      (clk),
        .rst      (rst),
        .rd_bank  (req_bank),
        .rd_open  (bank_open),
        .rd_row   (bank_row),
        .set_open (tbl_set),
        .clr_open (tbl_clr),
        .wr_bank  (emit.ba),
        .wr_row   (src.row)
    );

    ddr_seq_cmd_reg u_cmd (
        .clk   (clk),
        .rst   (rst),
        .nxt   (emit),
        .cs_n  (cmd_cs_n),
        .ras_n (cmd_ras_n),
        .cas_n (cmd_cas_n),
        .we_n  (cmd_we_n),
        .ba    (cmd_ba),
        .addr  (cmd_addr)
    );
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        cmd_cs_n,
    input logic        cmd_ras_n,
    input logic        cmd_cas_n,
    input logic        cmd_we_n,
    input logic [12:0] cmd_addr
);
    logic [3:0] pins;
    logic       is_act, is_pre, is_col, is_nop;
    logic [7:0] since_act, since_pre;

    assign pins   = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    assign is_act = (pins == 4'b0011);
    assign is_pre = (pins == 4'b0010);
    assign is_nop = (pins == 4'b0111);
    assign is_col = (pins == 4'b0101) || (pins == 4'b0100);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 8'd0;
            since_pre <= 8'hFF;
        end else begin
            since_act <= is_act ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
            since_pre <= is_pre ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
        end
    end

    // R3: column command never earlier than T_RCD after an ACTIVE
    assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (since_act >= 8'(T_RCD)));

    // R3: column address has zeros on the unused bits
    assert_col_addr_R3: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (cmd_addr[12:11] == 2'b00 && cmd_addr[9] == 1'b0));

    // R5: ACTIVE never earlier than T_RP after a PRECHARGE
    assert_rp_gap_R5: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_pre >= 8'(T_RP)));

    // R5: PRECHARGE addresses a single bank
    assert_pre_single_R5: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (cmd_addr == 13'd0));

    // R8: acceptance makes the block busy on the next cycle
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2: an acceptance produces a command on the bus at once
    assert_cmd_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !is_nop);

    // R9: only the five known encodings appear
    assert_legal_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        is_nop || is_act || is_pre || is_col);
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_ras_n (cmd_ras_n),
    .cmd_cas_n (cmd_cas_n),
    .cmd_we_n  (cmd_we_n),
    .cmd_addr  (cmd_addr)
);

// File: tb/ddr_cmd_seq_tb.sv
`timescale 1ns/1ps
module ddr_cmd_seq_tb;
    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int T_WR  = 2;

    localparam logic [3:0] E_NOP = 4'b0111;
    localparam logic [3:0] E_ACT = 4'b0011;
    localparam logic [3:0] E_RD  = 4'b0101;
    localparam logic [3:0] E_WR  = 4'b0100;
    localparam logic [3:0] E_PRE = 4'b0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic        req_autopre = 1'b0;
    logic [1:0]  req_burst = '0;
    logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [1:0]  cmd_ba;
    logic [12:0] cmd_addr;

    ddr_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_autopre(req_autopre), .req_burst(req_burst),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [3:0]  kind;
        logic [1:0]  ba;
        logic [12:0] addr;
        int          t;
        string       tag;
    } exp_t;

    exp_t  sb[$];
    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 0;
    bit    model_open[4];
    logic [12:0] model_row[4];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every command on the bus must match the next expected one
    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] k;
            k = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
            if (k != E_NOP) begin
                total++;
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL R9: unexpected cmd=%b ba=%0d addr=%h at %0d, expected none",
                             k, cmd_ba, cmd_addr, cyc);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (k != e.kind || cmd_ba != e.ba || cmd_addr != e.addr || cyc != e.t) begin
                        bad++;
                        $display("FAIL %s: got cmd=%b ba=%0d addr=%h t=%0d, expected cmd=%b ba=%0d addr=%h t=%0d",
                                 e.tag, k, cmd_ba, cmd_addr, cyc, e.kind, e.ba, e.addr, e.t);
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bclk(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    task automatic push(input logic [3:0] k, input logic [1:0] ba,
                        input logic [12:0] a, input int t, input string tag);
        exp_t e;
        e.kind = k; e.ba = ba; e.addr = a; e.t = t; e.tag = tag;
        sb.push_back(e);
    endtask

    // Driver: compute the expected command series, then offer the request
    task automatic do_req(input logic wr, input logic [1:0] bank, input logic [12:0] row,
                          input logic [8:0] col, input logic ap, input logic [1:0] bc,
                          input string tag);
        int t0, tc, hold, seen;
        logic [12:0] ca;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        t0 = cyc + 1;
        ca = {2'b00, ap, 1'b0, col};
        if (model_open[bank] && model_row[bank] == row) begin
            tc = t0;
        end else if (model_open[bank]) begin
            push(E_PRE, bank, 13'd0, t0, "R5");
            push(E_ACT, bank, row, t0 + T_RP, "R5");
            tc = t0 + T_RP + T_RCD;
        end else begin
            push(E_ACT, bank, row, t0, "R2");
            tc = t0 + T_RCD;
        end
        push(wr ? E_WR : E_RD, bank, ca, tc, tag);
        model_open[bank] = !ap;
        model_row[bank]  = row;
        hold = bclk(bc) + (wr ? T_WR : 0) + (ap ? T_RP : 0);
        req_valid = 1'b1; req_write = wr; req_bank = bank; req_row = row;
        req_col = col; req_autopre = ap; req_burst = bc;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 busy after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        seen = cyc;
        check({tag, " R7/R8 ready return"}, seen, tc + hold);
    endtask

    initial begin
        for (int b = 0; b < 4; b++) begin
            model_open[b] = 0;
            model_row[b]  = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", req_ready, 1);
        check("R1 NOP after reset", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, E_NOP);
        check("R1 addr after reset", cmd_addr, 0);

        do_req(1'b0, 2'd0, 13'd5,    9'd10,  1'b0, 2'd1, "R2/R3 closed read");
        do_req(1'b0, 2'd0, 13'd5,    9'd20,  1'b0, 2'd2, "R4 hit read");
        do_req(1'b1, 2'd0, 13'd9,    9'd3,   1'b0, 2'd0, "R5 miss write");
        do_req(1'b1, 2'd1, 13'd100,  9'd511, 1'b1, 2'd2, "R3 autopre write");
        do_req(1'b0, 2'd1, 13'd100,  9'd0,   1'b0, 2'd1, "R6 reopen after autopre");
        do_req(1'b0, 2'd3, 13'd8191, 9'd7,   1'b0, 2'd3, "R7 code3 read");
        do_req(1'b0, 2'd3, 13'd8191, 9'd256, 1'b1, 2'd0, "R7 hit autopre read");
        do_req(1'b1, 2'd2, 13'd4096, 9'd1,   1'b0, 2'd1, "R4 bank2 write");
        do_req(1'b1, 2'd2, 13'd4096, 9'd2,   1'b0, 2'd1, "R4 bank2 hit write");

        // R9: fields toggle with req_valid low, nothing may be issued
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req_bank = 2'(i); req_row = 13'(i * 977); req_col = 9'(i * 31);
            req_write = i[0]; req_autopre = i[1];
            check("R9 idle stays ready", req_ready, 1);
        end
        repeat (3) @(negedge clk);
        do_req(1'b0, 2'd0, 13'd1, 9'd4, 1'b0, 2'd2, "R5 second miss");
        repeat (4) @(negedge clk);
        check("R9 no pending commands", sb.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule